// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter with Filter Restart

This block turns the one-bit output of a sigma-delta modulator into signed-range conversion words at a programmable output rate. Each accepted modulator bit counts as +1 or -1. The bits pass through a cubic sinc response, built from three running-sum stages at the modulator rate and three differencing stages at the output rate. The output period is one decimation ratio of accepted samples, so the word rate matches the first notch of the filter. A three-bit rate code selects the ratio: a clock-range bit concatenated with a two-bit rate select.

A sync input holds every accumulator, every difference stage, the sample counter and the warm-up sequencer at zero. When sync is released, the filter starts from a clean state. It publishes nothing until three full output periods have gone by. That is the point at which the cubic response covers only samples taken after the restart. Sync leaves the published word and an already-low ready flag as they are. The same warm-up applies when the rate code changes: the new ratio takes effect at the next period boundary, and the filter restarts there.

Published words are 16 bits wide. They are offset binary in bipolar mode and straight binary, floored at zero, in unipolar mode. An active-low ready flag falls when a word is loaded. It rises again when the consumer acknowledges the word, and also for the single cycle before a newer word replaces it.

Top module: `sinc3_decim`

## Requirements
- R1: With a modulator pattern that repeats every P accepted samples (P divides the ratio N), and with ones making up a fraction f of each repeat, every published word encodes the signed level s = 32768·(2f−1). A 1 bit weighs +1 and a 0 bit weighs −1.
- R2: While `sync` is high, no word is published and all filter state is cleared. After release, the words reflect only samples taken after the release.
- R3: With a sample accepted on every cycle, the first word after `sync` falls is flagged on clock edge 3N+2, counting the first edge with `sync` low as edge 1.
- R4: Once warmed up, words are published exactly once per N accepted samples, and never otherwise.
- R5: The decimation ratio is N = 2^(LOG_MIN_RATIO + code), where code = {`clk_range`, `rate_sel`} is read as an unsigned 3-bit number. With the default parameter, code 0 gives N = 4 and code 6 gives N = 256.
- R6: A change of code is adopted only while `sync` is high or at the sample that ends an output period. Adopting it at a boundary discards that period, restarts the filter, and delays the next word by three periods of the new ratio.
- R7: `data_ready_n` is 0 in every cycle that `word_valid` is high. It is 1 in the cycle just before each new word is loaded. It becomes 1 one cycle after a `word_taken` pulse if no word is being loaded in that cycle.
- R8: Raising `sync` changes neither `dout` nor a low `data_ready_n`.
- R9: In bipolar mode (`unipolar` = 0), `dout` = clamp(s + 32768, 0, 65535).
- R10: In unipolar mode (`unipolar` = 1), `dout` = clamp(2·s, 0, 65535), so every negative level reads 0.
- R11: After reset, `data_ready_n` = 1, `word_valid` = 0 and `dout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| mod_strobe | input | 1 | Accept `mod_bit` on this edge |
| clk_range | input | 1 | Upper bit of the rate code |
| rate_sel | input | 2 | Lower bits of the rate code |
| unipolar | input | 1 | 1 = straight binary, 0 = offset binary |
| sync | input | 1 | Hold filter and sequencer in restart |
| word_taken | input | 1 | Consumer acknowledges the current word |
| dout | output | 16 | Most recent published word |
| word_valid | output | 1 | One-cycle pulse when `dout` is loaded |
| data_ready_n | output | 1 | Sticky active-low word-available flag |

## Verification
The hardest case to reach is a rate-code change while words are flowing. It only matters if it lands strictly inside an output period, and its effect shows up as a single longer gap that mixes the old and the new ratio. The stimulus changes the code in the cycle right after a published word, when the bench knows that the current period has just begun. It then times the gap to the next word against one old period plus three new ones. A second hard case is `sync` rising while the ready flag is low. To reach it, the bench raises `sync` immediately after a word it has not acknowledged and watches the flag and the word for many cycles. It then restarts with the opposite input level, to show that no earlier state survived.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    // number of running-sum and difference stages (cubic response)
    localparam int ORDER  = 3;
    // rate code = {clock-range bit, two rate bits}
    localparam int RATE_W = 2;
    localparam int CODE_W = RATE_W + 1;

    // output periods seen since the last restart
    typedef enum logic [1:0] {
        WARM0     = 2'd0,
        WARM1     = 2'd1,
        WARM2     = 2'd2,
        WARM_DONE = 2'd3
    } warm_e;

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ
    import sinc3_pkg::*;
#(
    parameter int ACC_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [ACC_W-1:0] acc_out
);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] acc;
    } integ_st_t;

    integ_st_t st_d, st_q;
    logic [ACC_W-1:0] step_val;

    always_comb begin
        st_d     = st_q;
        step_val = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            for (int i = 0; i < ORDER; i++) begin
                if (i == 0) begin
                    st_d.acc[i] = st_q.acc[i] + step_val;
                end else begin
                    st_d.acc[i] = st_q.acc[i] + st_d.acc[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out = st_q.acc[ORDER-1];

    AST_INTEG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_out == '0)); // R2

    AST_INTEG_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> ((st_q.acc[0] - $past(st_q.acc[0]))
                          == ($past(bit_in) ? ACC_W'(1) : {ACC_W{1'b1}}))); // R1

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
    import sinc3_pkg::*;
#(
    parameter int ACC_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] in_val,
    output logic [ACC_W-1:0] out_val
);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
    } comb_st_t;

    comb_st_t st_d, st_q;
    logic [ORDER-1:0][ACC_W-1:0] diff;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ORDER; i++) begin
            if (i == 0) begin
                diff[i] = in_val - st_q.dly[i];
            end else begin
                diff[i] = diff[i-1] - st_q.dly[i];
            end
        end
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            for (int i = 0; i < ORDER; i++) begin
                st_d.dly[i] = (i == 0) ? in_val : diff[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_val = diff[ORDER-1];

    AST_COMB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.dly == '0)); // R2

endmodule

// File: rtl/sinc3_fmt.sv
module sinc3_fmt #(
    parameter int ACC_W = 29,
    parameter int OUT_W = 16,
    parameter int LOG_W = 4
) (
    input  logic [ACC_W-1:0] res,
    input  logic [LOG_W-1:0] log_r,
    input  logic             unipolar,
    output logic [OUT_W-1:0] word
);

    localparam int EW = ACC_W + OUT_W + 1;
    localparam logic signed [EW-1:0] HALF = EW'(1) <<< (OUT_W - 1);
    localparam logic signed [EW-1:0] MAXV = (EW'(1) <<< OUT_W) - EW'(1);

    logic signed [EW-1:0] wide;
    logic signed [EW-1:0] level;
    logic signed [EW-1:0] coded;
    logic [LOG_W+1:0]     sh;

    always_comb begin
        // full scale is N^3 = 2^(3*log_r); rescale it to half the output range
        sh    = {2'b00, log_r} + {1'b0, log_r, 1'b0};
        wide  = {{(EW-ACC_W){res[ACC_W-1]}}, res};
        level = (wide <<< (OUT_W - 1)) >>> sh;
        coded = unipolar ? (level <<< 1) : (level + HALF);
        if (coded < 0) begin
            word = '0;
        end else if (coded > MAXV) begin
            word = '1;
        end else begin
            word = coded[OUT_W-1:0];
        end
    end

    AST_FMT_RANGE: assert final (!(unipolar && (level <= 0)) || (word == '0)); // R10

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int LOG_MIN_RATIO = 2,
    parameter int OUT_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_bit,
    input  logic              mod_strobe,
    input  logic              clk_range,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              unipolar,
    input  logic              sync,
    input  logic              word_taken,
    output logic [OUT_W-1:0]  dout,
    output logic              word_valid,
    output logic              data_ready_n
);

    localparam int LOG_MAX = LOG_MIN_RATIO + (1 << CODE_W) - 1;
    localparam int ACC_W   = 3 * LOG_MAX + 2;
    localparam int CNT_W   = LOG_MAX;
    localparam int LOG_W   = $clog2(LOG_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        warm_e             warm;
        logic              dec;
        logic              pend;
        logic [OUT_W-1:0]  pend_word;
        logic [OUT_W-1:0]  dout;
        logic              valid;
        logic              rdy_n;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [CODE_W-1:0] code_in;
    logic [LOG_W-1:0]  log_r;
    logic [CNT_W:0]    last_idx;
    logic              at_last;
    logic              restart;
    logic              filt_clr;
    logic [ACC_W-1:0]  integ_out;
    logic [ACC_W-1:0]  comb_out;
    logic [OUT_W-1:0]  fmt_word;

    assign code_in  = {clk_range, rate_sel};
    assign log_r    = LOG_W'(LOG_MIN_RATIO) + LOG_W'(st_q.code);
    assign last_idx = ((CNT_W+1)'(1) << log_r) - (CNT_W+1)'(1);
    assign at_last  = ({1'b0, st_q.cnt} == last_idx);
    assign restart  = mod_strobe && at_last && (code_in != st_q.code) && !sync;
    assign filt_clr = sync || restart;

    sinc3_integ #(.ACC_W(ACC_W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (filt_clr),
        .en      (mod_strobe && !sync),
        .bit_in  (mod_bit),
        .acc_out (integ_out)
    );

    sinc3_comb #(.ACC_W(ACC_W)) u_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (filt_clr),
        .en      (st_q.dec && !sync),
        .in_val  (integ_out),
        .out_val (comb_out)
    );

    sinc3_fmt #(.ACC_W(ACC_W), .OUT_W(OUT_W), .LOG_W(LOG_W)) u_fmt (
        .res      (comb_out),
        .log_r    (log_r),
        .unipolar (unipolar),
        .word     (fmt_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.dec   = 1'b0;
        st_d.pend  = 1'b0;
        if (sync) begin
            st_d.cnt  = '0;
            st_d.code = code_in;
            st_d.warm = WARM0;
        end else begin
            // one decimated sample through the difference stages
            if (st_q.dec) begin
                if (st_q.warm == WARM2 || st_q.warm == WARM_DONE) begin
                    st_d.pend      = 1'b1;
                    st_d.pend_word = fmt_word;
                    st_d.rdy_n     = 1'b1;
                end
                if (st_q.warm != WARM_DONE) begin
                    st_d.warm = warm_e'(st_q.warm + 2'd1);
                end
            end
            // sample counting and period boundary
            if (mod_strobe) begin
                if (at_last) begin
                    st_d.cnt = '0;
                    if (restart) begin
                        st_d.code = code_in;
                        st_d.warm = WARM0;
                    end else begin
                        st_d.dec = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            // publish
            if (st_q.pend) begin
                st_d.dout  = st_q.pend_word;
                st_d.valid = 1'b1;
                st_d.rdy_n = 1'b0;
            end
        end
        if (word_taken && !(st_q.pend && !sync)) begin
            st_d.rdy_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.code  <= 3'b110;
            st_q.warm  <= WARM0;
            st_q.rdy_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout         = st_q.dout;
    assign word_valid   = st_q.valid;
    assign data_ready_n = st_q.rdy_n;

    AST_NO_WORD_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !word_valid); // R2

    AST_WORD_AFTER_WARMUP: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (st_q.warm == WARM_DONE)); // R3

    AST_WORD_LOWERS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !data_ready_n); // R7

    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(dout)); // R8

    AST_SYNC_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !data_ready_n && !word_taken) |=> !data_ready_n); // R8

    AST_RATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && !(mod_strobe && at_last)) |=> $stable(st_q.code)); // R6

endmodule

// File: tb/sinc3_decim_tb_top.sv
module sinc3_decim_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_range = 1'b1;
    logic [1:0]  rate_sel = 2'b10;
    logic        unipolar = 1'b0;
    logic        sync = 1'b1;
    logic        word_taken = 1'b0;
    logic        mod_bit;
    logic        mod_strobe;
    logic [15:0] dout;
    logic        word_valid;
    logic        data_ready_n;

    logic [15:0] pat_bits = 16'h0001;
    int          pat_len = 1;
    logic        half_rate = 1'b0;
    int          idx = 0;
    logic        phase = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int          exp_val[$];
    string       exp_tag[$];

    always #4 clk = ~clk;

    sinc3_decim dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_bit      (mod_bit),
        .mod_strobe   (mod_strobe),
        .clk_range    (clk_range),
        .rate_sel     (rate_sel),
        .unipolar     (unipolar),
        .sync         (sync),
        .word_taken   (word_taken),
        .dout         (dout),
        .word_valid   (word_valid),
        .data_ready_n (data_ready_n)
    );

    // modulator stream source
    always @(posedge clk) begin
        if (sync) begin
            idx   <= 0;
            phase <= 1'b1;
        end else begin
            if (mod_strobe) idx <= idx + 1;
            phase <= ~phase;
        end
    end
    assign mod_strobe = half_rate ? phase : 1'b1;
    assign mod_bit    = pat_bits[4'(idx % pat_len)];

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_word(int ones, int len, bit uni);
        int s;
        int t;
        s = (32768 * (2 * ones - len)) / len;
        t = uni ? 2 * s : s + 32768;
        if (t < 0) t = 0;
        if (t > 65535) t = 65535;
        return t;
    endfunction

    task automatic push(int v, string tag, int count);
        for (int i = 0; i < count; i++) begin
            exp_val.push_back(v);
            exp_tag.push_back(tag);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (exp_val.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R4 unexpected word actual=%0d expected=none", dout);
            end else begin
                check(exp_tag.pop_front(), int'(dout), exp_val.pop_front());
            end
        end
    end

    task automatic setup(int code, logic [15:0] bits, int len, bit uni, bit half);
        @(negedge clk);
        sync = 1'b1;
        {clk_range, rate_sel} = 3'(code);
        pat_bits  = bits;
        pat_len   = len;
        unipolar  = uni;
        half_rate = half;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_valid(output int edges);
        edges = 0;
        do begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end while (!word_valid && edges < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int e;
        int lastr;
        int d0;
        bit ok;
        repeat (5) @(negedge clk);
        check("R11 ready after reset", int'(data_ready_n), 1);
        check("R11 valid after reset", int'(word_valid), 0);
        check("R11 dout after reset", int'(dout), 0);
        rst_n = 1'b1;

        // T1: default code 6 (N=256), all ones, bipolar
        setup(6, 16'h0001, 1, 1'b0, 1'b0);
        push(exp_word(1, 1, 1'b0), "R9 full scale", 2);
        sync = 1'b0;
        wait_valid(e);
        check("R3 first word N=256", e, 3 * 256 + 2);
        wait_valid(e);
        check("R4 spacing N=256", e, 256);
        sync = 1'b1;

        // T2: code 0 (N=4), alternating, bipolar
        setup(0, 16'h0001, 2, 1'b0, 1'b0);
        push(exp_word(1, 2, 1'b0), "R1 zero level", 4);
        sync = 1'b0;
        wait_valid(e);
        check("R3 first word N=4", e, 14);
        for (int i = 0; i < 3; i++) begin
            wait_valid(e);
            check("R4 spacing N=4", e, 4);
        end
        sync = 1'b1;

        // T3: code 1 (N=8), three ones in four, unipolar
        setup(1, 16'h0007, 4, 1'b1, 1'b0);
        push(exp_word(3, 4, 1'b1), "R10 half level", 3);
        sync = 1'b0;
        wait_valid(e);
        check("R5 first word code 1", e, 26);
        for (int i = 0; i < 2; i++) begin
            wait_valid(e);
            check("R5 spacing code 1", e, 8);
        end
        sync = 1'b1;

        // T4: code 2 (N=16), one one in four: unipolar floors, bipolar quarter
        setup(2, 16'h0001, 4, 1'b1, 1'b0);
        push(exp_word(1, 4, 1'b1), "R10 negative floors", 2);
        sync = 1'b0;
        wait_valid(e);
        check("R5 first word code 2", e, 50);
        wait_valid(e);
        sync = 1'b1;
        setup(2, 16'h0001, 4, 1'b0, 1'b0);
        push(exp_word(1, 4, 1'b0), "R9 quarter level", 2);
        sync = 1'b0;
        wait_valid(e);
        wait_valid(e);
        sync = 1'b1;

        // T5: all zeros bipolar
        setup(0, 16'h0000, 1, 1'b0, 1'b0);
        push(exp_word(0, 1, 1'b0), "R9 negative full scale", 2);
        sync = 1'b0;
        wait_valid(e);
        wait_valid(e);
        sync = 1'b1;

        // T6: sample every other cycle, N=8, unipolar all ones
        setup(1, 16'h0001, 1, 1'b1, 1'b1);
        push(exp_word(1, 1, 1'b1), "R10 full scale", 3);
        sync = 1'b0;
        wait_valid(e);
        for (int i = 0; i < 2; i++) begin
            wait_valid(e);
            check("R4 spacing half rate", e, 16);
        end
        sync = 1'b1;

        // T7: ready flag behaviour
        setup(0, 16'h0001, 1, 1'b0, 1'b0);
        push(65535, "R1 ready test word", 2);
        sync = 1'b0;
        wait_valid(e);
        check("R7 low on load", int'(data_ready_n), 0);
        lastr = -1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (word_valid) break;
            lastr = int'(data_ready_n);
        end
        check("R7 high before overwrite", lastr, 1);
        check("R7 low on second load", int'(data_ready_n), 0);
        word_taken = 1'b1;
        @(negedge clk);
        word_taken = 1'b0;
        sync = 1'b1;
        check("R7 high after read", int'(data_ready_n), 1);

        // T8: sync with ready low, then clean restart
        setup(0, 16'h0001, 1, 1'b0, 1'b0);
        push(65535, "R1 before sync", 1);
        sync = 1'b0;
        wait_valid(e);
        d0 = int'(dout);
        sync = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (data_ready_n !== 1'b0 || int'(dout) != d0) ok = 1'b0;
        end
        check("R8 ready and word kept in sync", int'(ok), 1);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (word_valid) ok = 1'b0;
        end
        check("R2 silent during sync", int'(ok), 1);
        setup(0, 16'h0000, 1, 1'b0, 1'b0);
        push(0, "R2 no stale state", 1);
        sync = 1'b0;
        wait_valid(e);
        check("R2 restart timing", e, 14);
        sync = 1'b1;

        // T9: rate change at a boundary
        setup(0, 16'h0001, 1, 1'b0, 1'b0);
        push(65535, "R6 words around change", 4);
        sync = 1'b0;
        wait_valid(e);
        wait_valid(e);
        rate_sel = 2'b01;
        wait_valid(e);
        check("R6 gap across change", e, 4 + 3 * 8);
        wait_valid(e);
        check("R6 new spacing", e, 8);
        sync = 1'b1;

        repeat (4) @(negedge clk);
        check("R4 all expected words seen", exp_val.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule